// File: doc/BRIEF.md
# Burst Read Data Capture Path

This block takes 32-bit read data from a synchronous processor bus and hands it to the core, either as one word for a single-beat read or as a complete four-word line for a burst read. A transfer begins with a one-cycle start pulse that gives the transfer kind and the starting longword index (address bits [3:2]). Each beat then ends on the rising clock edge at which the transfer-acknowledge input is high. On a line read the responding device steps the longword index by one per beat and wraps modulo four. The block tracks this order and writes every word into its proper slot of a line buffer.

Two capture modes exist, and the mode is taken from a strap pin while reset is held. In edge mode the word on the bus at the acknowledging clock edge is stored. In hold mode a transparent latch sits in front of the storage. While the hold enable input is low the latch follows the bus. Once the enable is high the latch keeps its value, so a device can settle the data before the clock edge arrives and then release the bus. The hold enable only decides which value is stored. Beat counting and transfer completion depend on the acknowledge input alone.

Top module: `rd_line_capture`

## Requirements
- R1: The capture mode is loaded from `strap_hold_n` only while `rst_n` is low. A low strap selects hold mode and a high strap selects edge mode. Changes on the strap after reset has been released have no effect.
- R2: In edge mode, the stored word is the value on `bus_data` at the rising edge where `xfer_ack` is sampled high during an open transfer. The level of `hold_en` has no effect in this mode.
- R3: In hold mode, if `hold_en` stays low through a beat, the latch is transparent and the word stored is the `bus_data` value present at the acknowledging edge.
- R4: In hold mode, if `hold_en` is raised during a beat, the word stored is the `bus_data` value present when `hold_en` rose. Later bus changes before the edge are not stored.
- R5: `hold_en` does not affect beat counting or completion. A line read completes on its fourth acknowledged beat, whatever `hold_en` does during wait cycles or beats.
- R6: A line read that starts at index `s` writes beat `b` (0 to 3) into slot `(s+b) mod 4`. Slot `i` appears on `line_data[32*i+31:32*i]`, for example 01, 10, 11, 00 for `s`=1.
- R7: `line_valid` is high for exactly the one cycle after the clock edge of the fourth acknowledged beat of a line read, and it is low throughout all earlier cycles of that transfer.
- R8: For a single read (`xfer_line`=0), `word_valid` is high for exactly the one cycle after the acknowledging edge, and `word_data` holds the captured word. `line_data` is left unchanged.
- R9: A `xfer_start` that arrives while a transfer is open is ignored. An `xfer_ack` while no transfer is open stores nothing and raises no valid output.
- R10: After reset, `line_data` and `word_data` are zero and both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all capture happens on the rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| strap_hold_n | input | 1 | Mode strap, sampled during reset; low selects hold mode |
| xfer_start | input | 1 | One-cycle pulse that opens a read transfer |
| xfer_line | input | 1 | With start: 1 = four-beat line read, 0 = single read |
| xfer_index | input | 2 | With start: starting longword index (address bits [3:2]) |
| xfer_ack | input | 1 | Transfer acknowledge; ends a beat at the rising edge |
| hold_en | input | 1 | Latch enable; high freezes the read data in hold mode |
| bus_data | input | 32 | Read data bus |
| line_valid | output | 1 | One-cycle pulse: line buffer complete |
| line_data | output | 128 | Line buffer, slot i at bits [32*i+31:32*i] |
| word_valid | output | 1 | One-cycle pulse: single-read word ready |
| word_data | output | 32 | Word captured by the last single read |

## Verification
Each stored word is fixed at the rising edge where the acknowledge is sampled. Both valid pulses and the updated buffer or word register can be seen in the cycle that follows that edge. The bench drives inputs at the falling edge and samples one falling edge after the acknowledging beat, so it looks exactly one register stage after the capture. In hold mode it raises the hold enable partway through the beat and then changes the bus a nanosecond later, before the rising edge. The expected word is therefore either the early or the late value, and the choice follows only from the mode and the enable. On every cycle before the final beat the bench also confirms that `line_valid` is still low, and it confirms that the pulse has fallen one cycle after it appears.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  typedef enum logic {
    CAP_EDGE = 1'b0,
    CAP_HOLD = 1'b1
  } cap_mode_e;

  typedef enum logic {
    XFER_SINGLE = 1'b0,
    XFER_LINE   = 1'b1
  } xfer_kind_e;

endpackage

// File: rtl/rlc_mode_reg.sv
module rlc_mode_reg
  import rlc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strap_hold_n,
  output cap_mode_e cap_mode
);

  cap_mode_e mode_d;
  cap_mode_e mode_q;

  // load enable is the reset itself: the strap is only observed while held
  always_comb begin
    mode_d = mode_q;
    if (!rst_n) begin
      mode_d = strap_hold_n ? CAP_EDGE : CAP_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
  end

  assign cap_mode = mode_q;

endmodule

// File: rtl/rlc_hold_latch.sv
module rlc_hold_latch
  import rlc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cap_mode_e          cap_mode,
  input  logic               hold_en,
  input  logic [DATA_W-1:0]  bus_data,
  output logic [DATA_W-1:0]  cap_data
);

  logic [DATA_W-1:0] latch_q;

  // transparent while the enable is low, frozen while it is high
  always_latch begin
    if (!hold_en) begin
      latch_q = bus_data;
    end
  end

  always_comb begin
    if (cap_mode == CAP_HOLD) begin
      cap_data = latch_q;
    end else begin
      cap_data = bus_data;
    end
  end

endmodule

// File: rtl/rlc_beat_track.sv
module rlc_beat_track
  import rlc_pkg::*;
#(
  parameter int LINE_BEATS = 4,
  localparam int SLOT_W = $clog2(LINE_BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  xfer_kind_e        xfer_kind,
  input  logic [SLOT_W-1:0] xfer_index,
  input  logic              xfer_ack,
  output logic              busy,
  output logic              line_wr_en,
  output logic              word_wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              line_done,
  output logic              word_done
);

  localparam logic [SLOT_W-1:0] LAST_BEAT = SLOT_W'(LINE_BEATS - 1);
  localparam logic [SLOT_W-1:0] ONE       = SLOT_W'(1);

  logic              busy_d, busy_q;
  xfer_kind_e        kind_d, kind_q;
  logic [SLOT_W-1:0] slot_d, slot_q;
  logic [SLOT_W-1:0] cnt_d,  cnt_q;
  logic              ldone_d, ldone_q;
  logic              wdone_d, wdone_q;
  logic              beat_end;

  assign beat_end = busy_q && xfer_ack;

  always_comb begin
    busy_d  = busy_q;
    kind_d  = kind_q;
    slot_d  = slot_q;
    cnt_d   = cnt_q;
    ldone_d = 1'b0;
    wdone_d = 1'b0;
    if (!busy_q) begin
      if (xfer_start) begin
        busy_d = 1'b1;
        kind_d = xfer_kind;
        slot_d = xfer_index;
        cnt_d  = '0;
      end
    end else if (xfer_ack) begin
      slot_d = slot_q + ONE;
      cnt_d  = cnt_q + ONE;
      if (kind_q == XFER_SINGLE) begin
        busy_d  = 1'b0;
        wdone_d = 1'b1;
      end else if (cnt_q == LAST_BEAT) begin
        busy_d  = 1'b0;
        ldone_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      kind_q  <= XFER_SINGLE;
      slot_q  <= '0;
      cnt_q   <= '0;
      ldone_q <= 1'b0;
      wdone_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      kind_q  <= kind_d;
      slot_q  <= slot_d;
      cnt_q   <= cnt_d;
      ldone_q <= ldone_d;
      wdone_q <= wdone_d;
    end
  end

  assign busy       = busy_q;
  assign line_wr_en = beat_end && (kind_q == XFER_LINE);
  assign word_wr_en = beat_end && (kind_q == XFER_SINGLE);
  assign wr_slot    = slot_q;
  assign line_done  = ldone_q;
  assign word_done  = wdone_q;

endmodule

// File: rtl/rlc_line_buf.sv
module rlc_line_buf #(
  parameter int DATA_W     = 32,
  parameter int LINE_BEATS = 4,
  localparam int SLOT_W = $clog2(LINE_BEATS),
  localparam int LINE_W = DATA_W * LINE_BEATS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_wr_en,
  input  logic              word_wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LINE_W-1:0] line_data,
  output logic [DATA_W-1:0] word_data
);

  for (genvar i = 0; i < LINE_BEATS; i++) begin : g_slot
    logic              slot_en;
    logic [DATA_W-1:0] slot_d, slot_q;

    assign slot_en = line_wr_en && (wr_slot == SLOT_W'(i));

    always_comb begin
      slot_d = slot_q;
      if (slot_en) begin
        slot_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else begin
        slot_q <= slot_d;
      end
    end

    assign line_data[i*DATA_W +: DATA_W] = slot_q;
  end

  logic [DATA_W-1:0] word_d, word_q;

  always_comb begin
    word_d = word_q;
    if (word_wr_en) begin
      word_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign word_data = word_q;

endmodule

// File: rtl/rd_line_capture.sv
module rd_line_capture
  import rlc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LINE_BEATS = 4,
  localparam int SLOT_W = $clog2(LINE_BEATS),
  localparam int LINE_W = DATA_W * LINE_BEATS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_hold_n,
  input  logic              xfer_start,
  input  logic              xfer_line,
  input  logic [SLOT_W-1:0] xfer_index,
  input  logic              xfer_ack,
  input  logic              hold_en,
  input  logic [DATA_W-1:0] bus_data,
  output logic              line_valid,
  output logic [LINE_W-1:0] line_data,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data
);

  cap_mode_e         cap_mode;
  logic [DATA_W-1:0] cap_data;
  logic              trk_busy;
  logic              line_wr_en;
  logic              word_wr_en;
  logic [SLOT_W-1:0] wr_slot;
  xfer_kind_e        xfer_kind;

  assign xfer_kind = xfer_line ? XFER_LINE : XFER_SINGLE;

  rlc_mode_reg u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_hold_n (strap_hold_n),
    .cap_mode     (cap_mode)
  );

  rlc_hold_latch #(
    .DATA_W (DATA_W)
  ) u_latch (
    .cap_mode (cap_mode),
    .hold_en  (hold_en),
    .bus_data (bus_data),
    .cap_data (cap_data)
  );

  rlc_beat_track #(
    .LINE_BEATS (LINE_BEATS)
  ) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_kind  (xfer_kind),
    .xfer_index (xfer_index),
    .xfer_ack   (xfer_ack),
    .busy       (trk_busy),
    .line_wr_en (line_wr_en),
    .word_wr_en (word_wr_en),
    .wr_slot    (wr_slot),
    .line_done  (line_valid),
    .word_done  (word_valid)
  );

  rlc_line_buf #(
    .DATA_W     (DATA_W),
    .LINE_BEATS (LINE_BEATS)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_wr_en (line_wr_en),
    .word_wr_en (word_wr_en),
    .wr_slot    (wr_slot),
    .wr_data    (cap_data),
    .line_data  (line_data),
    .word_data  (word_data)
  );

endmodule

// File: rtl/rd_line_capture_chk.sv
module rd_line_capture_chk
  import rlc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      xfer_ack,
  input logic      busy,
  input cap_mode_e cap_mode,
  input logic      line_valid,
  input logic      word_valid
);

  // mode is frozen once reset has been released for a cycle
  assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cap_mode));

  // line completion follows an acknowledged beat of an open transfer
  assert_line_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> $past(xfer_ack && busy));

  assert_line_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> !line_valid);

  assert_word_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_word_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(xfer_ack && busy));

  assert_one_kind_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_valid && word_valid));

  // with no open transfer, nothing can complete on the next cycle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (!line_valid && !word_valid));

endmodule

bind rd_line_capture rd_line_capture_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_ack   (xfer_ack),
  .busy       (trk_busy),
  .cap_mode   (cap_mode),
  .line_valid (line_valid),
  .word_valid (word_valid)
);

// File: tb/rd_line_capture_tb.sv
`timescale 1ns/1ps
module rd_line_capture_tb;

  logic         clk;
  logic         rst_n;
  logic         strap_hold_n;
  logic         xfer_start;
  logic         xfer_line;
  logic [1:0]   xfer_index;
  logic         xfer_ack;
  logic         hold_en;
  logic [31:0]  bus_data;
  logic         line_valid;
  logic [127:0] line_data;
  logic         word_valid;
  logic [31:0]  word_data;

  int unsigned n_checks;
  int unsigned n_fails;
  bit          hold_mode;
  logic [31:0] exp_buf [4];
  logic [31:0] exp_word;

  rd_line_capture u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_hold_n (strap_hold_n),
    .xfer_start   (xfer_start),
    .xfer_line    (xfer_line),
    .xfer_index   (xfer_index),
    .xfer_ack     (xfer_ack),
    .hold_en      (hold_en),
    .bus_data     (bus_data),
    .line_valid   (line_valid),
    .line_data    (line_data),
    .word_valid   (word_valid),
    .word_data    (word_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [127:0] pack_line();
    return {exp_buf[3], exp_buf[2], exp_buf[1], exp_buf[0]};
  endfunction

  function automatic logic [31:0] pick_word(bit hmode, bit used_hold,
                                            logic [31:0] early, logic [31:0] late);
    return (hmode && used_hold) ? early : late;
  endfunction

  function automatic logic [1:0] slot_of(logic [1:0] s, int b);
    return 2'((int'(s) + b) % 4);
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    xfer_start = 1'b0;
    xfer_line  = 1'b0;
    xfer_index = 2'd0;
    xfer_ack   = 1'b0;
    hold_en    = 1'b0;
    bus_data   = $urandom;
  endtask

  task automatic do_reset(bit strap);
    idle_inputs();
    strap_hold_n = strap;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(line_data == '0 && word_data == '0 && !line_valid && !word_valid,
          "R10 reset state", {line_valid, word_valid, line_data[63:0]}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    strap_hold_n = ~strap;   // R1: late strap change must not matter
    hold_mode = !strap;
    for (int i = 0; i < 4; i++) exp_buf[i] = '0;
    exp_word = '0;
  endtask

  // one acknowledged beat; returns the word that should be stored
  task automatic drive_beat(bit use_hold, output logic [31:0] stored);
    logic [31:0] early, late;
    early = $urandom;
    late  = $urandom;
    xfer_ack = 1'b1;
    hold_en  = 1'b0;
    bus_data = early;
    #2;
    if (use_hold) hold_en = 1'b1;
    #1;
    bus_data = late;
    stored = pick_word(hold_mode, use_hold, early, late);
    @(negedge clk);
    xfer_ack = 1'b0;
    hold_en  = 1'b0;
  endtask

  task automatic run_line(logic [1:0] sa, bit use_hold, bit waits, bit restart, string req);
    logic [31:0] w;
    bit early_lv;
    early_lv = 1'b0;
    xfer_start = 1'b1; xfer_line = 1'b1; xfer_index = sa;
    @(negedge clk);
    xfer_start = 1'b0;
    for (int b = 0; b < 4; b++) begin
      if (waits) begin
        for (int k = 0; k < int'($urandom % 3); k++) begin
          hold_en  = 1'($urandom);   // R5: wait-cycle enable activity
          bus_data = $urandom;
          @(negedge clk);
          early_lv |= line_valid;
        end
      end
      if (restart && b == 1) begin
        xfer_start = 1'b1; xfer_line = 1'b0; xfer_index = sa + 2'd2;  // R9
      end
      drive_beat(use_hold, w);
      xfer_start = 1'b0;
      exp_buf[slot_of(sa, b)] = w;
      if (b < 3) early_lv |= line_valid;
    end
    check(!early_lv, "R7 no early line_valid", 128'(early_lv), 128'd0);
    check(line_valid, "R7 line_valid after fourth beat", 128'(line_valid), 128'd1);
    check(line_data == pack_line(), req, line_data, pack_line());
    @(negedge clk);
    check(!line_valid && !word_valid, "R7 single-cycle line_valid",
          128'(line_valid), 128'd0);
  endtask

  task automatic run_single(logic [1:0] sa, bit use_hold, string req);
    logic [31:0] w;
    xfer_start = 1'b1; xfer_line = 1'b0; xfer_index = sa;
    @(negedge clk);
    xfer_start = 1'b0;
    drive_beat(use_hold, w);
    exp_word = w;
    check(word_valid && !line_valid, "R8 word_valid after beat", 128'(word_valid), 128'd1);
    check(word_data == exp_word, req, 128'(word_data), 128'(exp_word));
    check(line_data == pack_line(), "R8 line buffer untouched", line_data, pack_line());
    @(negedge clk);
    check(!word_valid, "R8 single-cycle word_valid", 128'(word_valid), 128'd0);
  endtask

  task automatic idle_ack();
    xfer_ack = 1'b1;
    bus_data = $urandom;
    @(negedge clk);
    xfer_ack = 1'b0;
    check(!line_valid && !word_valid, "R9 idle ack raises nothing",
          {126'd0, line_valid, word_valid}, 128'd0);
    @(negedge clk);
    check(line_data == pack_line() && word_data == exp_word, "R9 idle ack stores nothing",
          line_data ^ pack_line(), 128'd0);
  endtask

  task automatic random_mix(int n);
    for (int t = 0; t < n; t++) begin
      if ($urandom % 4 == 0) begin
        run_single(2'($urandom), 1'($urandom), "R8 R2 R4 random single word");
      end else begin
        run_line(2'($urandom), 1'($urandom), 1'b1, 1'($urandom),
                 "R6 R5 random line contents");
      end
      repeat ($urandom % 2) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1D5C_0A7E));
    n_checks = 0;
    n_fails  = 0;

    // edge mode: strap high during reset (R1)
    do_reset(1'b1);
    run_line(2'd1, 1'b0, 1'b0, 1'b0, "R6 R2 wrap order from index 1");
    run_line(2'd0, 1'b1, 1'b0, 1'b0, "R2 R1 enable ignored in edge mode");
    run_single(2'd2, 1'b1, "R2 R8 single word in edge mode");
    idle_ack();
    run_line(2'd3, 1'b0, 1'b0, 1'b1, "R9 restart during line ignored");
    random_mix(20);

    // hold mode: strap low during reset (R1)
    do_reset(1'b0);
    run_line(2'd2, 1'b1, 1'b0, 1'b0, "R4 R1 held value stored");
    run_line(2'd1, 1'b0, 1'b0, 1'b0, "R3 transparent latch stores late value");
    run_line(2'd3, 1'b1, 1'b1, 1'b0, "R5 enable activity in wait cycles");
    run_single(2'd0, 1'b1, "R4 R8 held single word");
    idle_ack();
    random_mix(20);

    finish_run();
  end

endmodule